// File: doc/BRIEF.md
# Multi-Channel Waveform Sample Capture

This block takes the filtered current samples of three phase channels and one neutral channel and holds a coherent snapshot of them in 24-bit signed registers. A single sample strobe, pulsed by the upstream filter chain at the fixed 8 kSPS output rate, loads all four holding registers on the same clock edge. The upstream datapath never waits on this block: the snapshot is taken in parallel and has no backpressure.

Each time a new snapshot lands, a sticky data-ready flag is set in the status word. A matching mask bit lets the flag drive an active-low, registered interrupt line. A simple synchronous register port reads back each sample as a 32-bit word, sign-extended from bit 23. The same port writes the mask and clears the flag with a write-1-to-clear access.

Top module: `wave_capture`

## Requirements
- R1: After reset every readable word (samples, status, mask) reads zero and `irq_n` is 1.
- R2: A one-cycle `smp_strobe` loads all four holding registers on the same edge from `smp_bus`: bits [23:0] phase A (address 0), [47:24] phase B (address 1), [71:48] phase C (address 2), [95:72] neutral (address 3).
- R3: With `smp_strobe` low, the holding registers keep their values whatever `smp_bus` does.
- R4: A read of address 0..3 returns the 24-bit sample in bits [23:0] with bits [31:24] all equal to bit 23. `reg_rdata` takes the value on the edge that samples `reg_rd_en` and holds it until the next read.
- R5: A strobe sets the ready flag, which reads as bit 17 of the status word (address 4; all other bits 0). The flag stays set until it is cleared.
- R6: Writing address 4 with bit 17 set clears the flag; a write with bit 17 clear leaves it. When a strobe falls in the same cycle as a clearing write, the flag stays set.
- R7: The mask is bit 17 of address 5, written from `reg_wdata[17]`; all other mask bits read 0.
- R8: `irq_n` is registered: one edge after the flag and the mask are both 1, it is 0; otherwise it is 1 one edge later.
- R9: Writes to addresses 0..3 and to unmapped addresses 6..7 change nothing; reads of 6..7 return zero.
- R10: A read issued in the same cycle as a strobe returns the value held before that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe | input | 1 | One-cycle pulse: new filtered sample set on `smp_bus` |
| smp_bus | input | 96 | Four 24-bit signed samples, phase A in the low bits |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Active-low registered data-ready interrupt |

## Verification
The assertions take for granted that every control input (`rst`, `smp_strobe`, `reg_wr_en`, `reg_rd_en`) holds a known 0 or 1 from the first clock edge. They also assume that `reg_addr` is defined whenever a read or write is requested. They do not assume that strobes are isolated from register accesses, so the clear-versus-set and read-versus-capture collisions stay legal.

The stimulus drives every input to a known value before reset is released. It changes inputs only on the falling edge and pulses each strobe for exactly one cycle. It deliberately places a strobe in the same cycle as a clearing write and as a read.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    // Default geometry of the capture block.
    localparam int unsigned DEF_NUM_CH  = 4;
    localparam int unsigned DEF_SMP_W   = 24;
    localparam int unsigned DEF_WORD_W  = 32;
    localparam int unsigned DEF_RDY_BIT = 17;

    // Kind of register selected by a word address.
    typedef enum logic [1:0] {
        RK_SAMPLE = 2'd0,
        RK_STATUS = 2'd1,
        RK_MASK   = 2'd2,
        RK_NONE   = 2'd3
    } reg_kind_e;

    // Decoded register access carried between the decode and the consumers.
    typedef struct packed {
        reg_kind_e kind;
        logic      wr;
        logic      rd;
    } reg_access_t;

    // Samples occupy the first n words, then status, then mask.
    function automatic reg_kind_e kind_of(input logic [31:0] a, input int unsigned n);
        if (a < n)            return RK_SAMPLE;
        else if (a == n)      return RK_STATUS;
        else if (a == n + 1)  return RK_MASK;
        else                  return RK_NONE;
    endfunction

endpackage

// File: rtl/wcap_sample_bank.sv
module wcap_sample_bank #(
    parameter int unsigned NUM_CH = wcap_pkg::DEF_NUM_CH,
    parameter int unsigned SMP_W  = wcap_pkg::DEF_SMP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strobe,
    input  logic [NUM_CH*SMP_W-1:0]  din,
    output logic [NUM_CH*SMP_W-1:0]  held
);

    // One holding register per channel, all loaded from the shared strobe.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                held[c*SMP_W +: SMP_W] <= '0;
            end else if (strobe) begin
                held[c*SMP_W +: SMP_W] <= din[c*SMP_W +: SMP_W];
            end
        end
    end

    // R2: the whole set follows the input bus of the strobe cycle
    a_r2_coherent_load: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (held == $past(din)));

    // R3: no strobe, no change
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(held));

endmodule

// File: rtl/wcap_status_irq.sv
module wcap_status_irq (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic clr_req,
    input  logic mask_we,
    input  logic mask_wbit,
    output logic flag,
    output logic mask,
    output logic irq_n
);

    // Sticky ready flag: a new capture outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (strobe) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= 1'b0;
        end else if (mask_we) begin
            mask <= mask_wbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~(flag & mask);
        end
    end

    // R5: a capture always leaves the flag set
    a_r5_set_on_strobe: assert property (@(posedge clk) disable iff (rst)
        strobe |=> flag);

    // R5: the flag only falls through an explicit clear
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    // R6: clear without a competing capture empties the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !strobe) |=> !flag);

    // R7: the mask moves only on its own write
    a_r7_mask_stable: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask));

    // R8: interrupt follows the enabled flag one edge later
    a_r8_irq_assert: assert property (@(posedge clk) disable iff (rst)
        (flag && mask) |=> !irq_n);

    a_r8_irq_release: assert property (@(posedge clk) disable iff (rst)
        !(flag && mask) |=> irq_n);

endmodule

// File: rtl/wcap_read_port.sv
module wcap_read_port
    import wcap_pkg::*;
#(
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned SMP_W   = DEF_SMP_W,
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned RDY_BIT = DEF_RDY_BIT,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  reg_access_t              acc,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CH*SMP_W-1:0]  held,
    input  logic                     flag,
    input  logic                     mask,
    output logic [WORD_W-1:0]        rdata
);

    localparam int unsigned EXT_W = WORD_W - SMP_W;

    logic [SMP_W-1:0]  picked;
    logic [WORD_W-1:0] word_nx;

    always_comb begin
        picked = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (32'(addr) == 32'(c)) begin
                picked = held[c*SMP_W +: SMP_W];
            end
        end
    end

    always_comb begin
        word_nx = '0;
        unique case (acc.kind)
            RK_SAMPLE: word_nx = {{EXT_W{picked[SMP_W-1]}}, picked};
            RK_STATUS: word_nx[RDY_BIT] = flag;
            RK_MASK:   word_nx[RDY_BIT] = mask;
            default:   word_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc.rd) begin
            rdata <= word_nx;
        end
    end

    // R4: sample words carry the sign bit through the upper byte
    a_r4_sign_ext: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.kind == RK_SAMPLE) |=>
            (rdata[WORD_W-1:SMP_W] == {EXT_W{rdata[SMP_W-1]}}));

    // R7: mask and status words use no bit but the ready position
    a_r7_single_bit: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && (acc.kind == RK_MASK || acc.kind == RK_STATUS)) |=>
            ((rdata & ~(WORD_W'(1) << RDY_BIT)) == '0));

    // R9: unmapped words read zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.kind == RK_NONE) |=> (rdata == '0));

    // R4: data holds between reads
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> $stable(rdata));

endmodule

// File: rtl/wave_capture.sv
module wave_capture
    import wcap_pkg::*;
#(
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned SMP_W   = DEF_SMP_W,
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned RDY_BIT = DEF_RDY_BIT,
    localparam int unsigned ADDR_W = $clog2(NUM_CH + 2),
    localparam int unsigned BUS_W  = NUM_CH * SMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_strobe,
    input  logic [BUS_W-1:0]  smp_bus,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_n
);

    reg_access_t       acc;
    logic [BUS_W-1:0]  held;
    logic              flag;
    logic              mask;
    logic              clr_req;
    logic              mask_we;

    always_comb begin
        acc.kind = kind_of(32'(reg_addr), NUM_CH);
        acc.wr   = reg_wr_en;
        acc.rd   = reg_rd_en;
    end

    // Only status and mask accept writes; everything else drops them.
    assign clr_req = acc.wr && (acc.kind == RK_STATUS) && reg_wdata[RDY_BIT];
    assign mask_we = acc.wr && (acc.kind == RK_MASK);

    wcap_sample_bank #(
        .NUM_CH (NUM_CH),
        .SMP_W  (SMP_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .strobe (smp_strobe),
        .din    (smp_bus),
        .held   (held)
    );

    wcap_status_irq u_stat (
        .clk       (clk),
        .rst       (rst),
        .strobe    (smp_strobe),
        .clr_req   (clr_req),
        .mask_we   (mask_we),
        .mask_wbit (reg_wdata[RDY_BIT]),
        .flag      (flag),
        .mask      (mask),
        .irq_n     (irq_n)
    );

    wcap_read_port #(
        .NUM_CH  (NUM_CH),
        .SMP_W   (SMP_W),
        .WORD_W  (WORD_W),
        .RDY_BIT (RDY_BIT),
        .ADDR_W  (ADDR_W)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .addr  (reg_addr),
        .held  (held),
        .flag  (flag),
        .mask  (mask),
        .rdata (reg_rdata)
    );

    // R9: a write aimed at a sample word leaves the snapshot alone
    a_r9_sample_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.kind == RK_SAMPLE && !smp_strobe) |=> $stable(held));

endmodule

// File: tb/wave_capture_bench.sv
`timescale 1ns/1ps
module wave_capture_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_strobe = 1'b0;
    logic [95:0] smp_bus = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_n;

    always #2 clk = ~clk;

    wave_capture u_wave_capture (
        .clk        (clk),
        .rst        (rst),
        .smp_strobe (smp_strobe),
        .smp_bus    (smp_bus),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_n      (irq_n)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model, built from the requirements
    logic [23:0] m_smp [4];
    logic        m_flag = 1'b0;
    logic        m_mask = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        mon_pending = 1'b0;

    function automatic logic [31:0] model_word(input int a);
        case (a)
            0, 1, 2, 3: return {{8{m_smp[a][23]}}, m_smp[a]};
            4:          return 32'(m_flag) << 17;
            5:          return 32'(m_mask) << 17;
            default:    return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read result against the queued expectation
    always @(posedge clk) mon_pending <= reg_rd_en;

    always @(negedge clk) begin
        if (mon_pending) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", reg_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(reg_rdata === e, t, reg_rdata, e);
            end
        end
    end

    // Driver tasks: called at a falling edge, return at a falling edge
    task automatic do_read(input int a, input string tag);
        reg_rd_en = 1'b1;
        reg_addr  = 3'(a);
        exp_q.push_back(model_word(a));
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = d;
        if (a == 4 && d[17]) m_flag = 1'b0;
        if (a == 5) m_mask = d[17];
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [95:0] pack4(input logic [23:0] a, input logic [23:0] b,
                                          input logic [23:0] c, input logic [23:0] n);
        return {n, c, b, a};
    endfunction

    task automatic capture(input logic [23:0] a, input logic [23:0] b,
                           input logic [23:0] c, input logic [23:0] n);
        smp_strobe = 1'b1;
        smp_bus    = pack4(a, b, c, n);
        m_smp[0] = a; m_smp[1] = b; m_smp[2] = c; m_smp[3] = n;
        m_flag = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) do_read(a, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_smp[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk(irq_n === 1'b1, "R1 irq_n after reset", 32'(irq_n), 32'h1);
        read_all("R1 reset word");

        // R2 / R4: mixed-sign capture
        capture(24'h123456, 24'h800000, 24'h7FFFFF, 24'hFFFFFF);
        for (int a = 0; a < 4; a++) do_read(a, "R2 R4 capture set 1");
        do_read(4, "R5 status after capture");

        // R3: bus moves without strobe
        smp_bus = pack4(24'h0F0F0F, 24'h00AAAA, 24'hC00001, 24'h000001);
        repeat (3) @(negedge clk);
        for (int a = 0; a < 4; a++) do_read(a, "R3 hold without strobe");

        // R7 / R8: enable mask, irq registered
        do_write(5, 32'hFFFF_FFFF);
        chk(irq_n === 1'b1, "R8 irq_n registered delay", 32'(irq_n), 32'h1);
        @(negedge clk);
        chk(irq_n === 1'b0, "R8 irq_n asserted", 32'(irq_n), 32'h0);
        do_read(5, "R7 mask word");

        // R6: writing 0 at bit 17 leaves the flag
        do_write(4, 32'hFFFD_FFFF);
        do_read(4, "R6 write without bit 17");
        chk(irq_n === 1'b0, "R6 irq still low", 32'(irq_n), 32'h0);

        // R6: write-1-to-clear
        do_write(4, 32'h0002_0000);
        do_read(4, "R6 cleared status");
        chk(irq_n === 1'b1, "R8 irq_n released", 32'(irq_n), 32'h1);

        // R6: capture and clear in the same cycle, capture wins
        smp_strobe = 1'b1;
        smp_bus    = pack4(24'h000010, 24'h000020, 24'h000030, 24'h800040);
        reg_wr_en  = 1'b1;
        reg_addr   = 3'd4;
        reg_wdata  = 32'h0002_0000;
        m_smp[0] = 24'h000010; m_smp[1] = 24'h000020;
        m_smp[2] = 24'h000030; m_smp[3] = 24'h800040;
        m_flag = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
        reg_wr_en  = 1'b0;
        do_read(4, "R6 strobe beats clear");
        do_read(3, "R2 R4 neutral negative");

        // R9: writes to sample and unmapped words are dropped
        do_write(0, 32'h0055_5555);
        do_write(2, 32'hFFFF_FFFF);
        do_write(7, 32'hFFFF_FFFF);
        do_write(6, 32'hFFFF_FFFF);
        for (int a = 0; a < 8; a++) do_read(a, "R9 ignored writes");

        // R10: read in the strobe cycle returns the prior value
        smp_strobe = 1'b1;
        smp_bus    = pack4(24'hABCDEF, 24'h111111, 24'h222222, 24'h333333);
        reg_rd_en  = 1'b1;
        reg_addr   = 3'd0;
        exp_q.push_back(model_word(0));
        tag_q.push_back("R10 read with strobe");
        m_smp[0] = 24'hABCDEF; m_smp[1] = 24'h111111;
        m_smp[2] = 24'h222222; m_smp[3] = 24'h333333;
        m_flag = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
        reg_rd_en  = 1'b0;
        do_read(0, "R10 read after strobe");

        // R8: with mask cleared, a set flag leaves irq_n high
        do_write(5, 32'h0);
        @(negedge clk);
        capture(24'h000001, 24'h000002, 24'h000003, 24'h000004);
        @(negedge clk);
        @(negedge clk);
        chk(irq_n === 1'b1, "R8 masked flag no irq", 32'(irq_n), 32'h1);
        do_read(4, "R5 flag set while masked");
        do_read(5, "R7 mask cleared");

        @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule